// File: doc/BRIEF.md
# Interrupt Ownership Token Moderator

This block decides when a device may interrupt its host driver. A single ownership token moves between the hardware and the driver. While the driver holds it, the driver is draining its completion queue and the block stays silent. When the driver is done, it writes the index of the last descriptor it handled. That write hands the token back to the hardware.

Once the hardware holds the token, the block compares the driver's last-handled index with the producer index, modulo the queue depth. As soon as the two differ, it emits a one-cycle interrupt request and passes the token to the driver. Work that was already queued at the moment of the hand-back counts as pending, so a stale hand-back leads straight to a new interrupt.

A single status word gives the interrupt cause, a protocol-error flag, the current owner and the producer index captured when the interrupt fired. The driver therefore needs one read per interrupt. That read clears the cause flags and leaves ownership alone.

Top module: `irq_token_moderator`

## Requirements
- R1: After reset the hardware holds the token (`drv_owns`=0), the last-handled index is 0, `irq_pulse` is 0 and `stat_data` is all zeros.
- R2: While the driver holds the token, `irq_pulse` stays 0 whatever the producer index does.
- R3: When the hardware holds the token and the registered producer index differs from the last-handled index, `irq_pulse` goes to 1 and `drv_owns` goes to 1 on the same edge. This happens two rising edges after `prod_idx` changes, because the producer index is registered first.
- R4: A hand-back write (`hb_wr`=1) while the driver holds the token stores `hb_idx` as the last-handled index and gives the token back to the hardware on that edge.
- R5: If the stored index differs from the producer index at hand-back, the interrupt fires on the very next edge after the hand-back took effect.
- R6: A hand-back write while the hardware already holds the token changes neither the token nor the last-handled index, and sets the protocol-error flag, status bit 1.
- R7: `irq_pulse` is high for exactly one cycle, and only on a transfer of the token from hardware to driver.
- R8: The work-cause flag (status bit 0) is set when an interrupt fires. A cycle with `stat_rd`=1 clears bits 0 and 1 on the following edge, and a set on that same edge wins over the clear. Reading never changes the token.
- R9: Status bit 2 shows `drv_owns` and bit 3 reads 0. Bits [IDX_W+3:4] hold the producer index that was registered when the last interrupt fired.
- R10: Indices wrap at DEPTH: a producer index that wraps to 0 counts as pending against a last-handled index of DEPTH-1, and it is no longer pending once 0 has been handed back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prod_idx | input | IDX_W | Hardware producer index, in range 0..DEPTH-1 |
| hb_wr | input | 1 | Driver hand-back write strobe |
| hb_idx | input | IDX_W | Last descriptor index handled by the driver |
| stat_rd | input | 1 | Status read strobe; clears the cause flags |
| stat_data | output | IDX_W+4 | Status word: {snapshot, 0, owner, error, work} |
| drv_owns | output | 1 | 1 while the driver holds the token |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume that the strobes and indices are known, clean values, sampled on the rising edge, and that every index stays below DEPTH. The bench drives all inputs on the falling edge and draws indices only from 0..DEPTH-1, so these assumptions hold. It deliberately issues hand-backs while the hardware owns the token, because the block must tolerate them. The producer index moves freely in the random phase, including wrap-around, which covers the case of pending work queued before a hand-back.

// File: rtl/itm_pkg.sv
// Shared definitions for the interrupt token moderator.
// Assumes status word layout is fixed by the bit positions below.
package itm_pkg;

    typedef enum logic {
        OWNER_HW  = 1'b0,
        OWNER_DRV = 1'b1
    } owner_t;

    localparam int ST_WORK_BIT = 0;
    localparam int ST_ERR_BIT  = 1;
    localparam int ST_OWN_BIT  = 2;
    localparam int ST_RSV_BIT  = 3;
    localparam int ST_SNAP_LSB = 4;

endpackage

// File: rtl/itm_gap.sv
// Pending-work detector: distance from the last-handled index to the
// producer index, modulo DEPTH. Assumes both indices are below DEPTH.
module itm_gap #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] prod_idx,
    input  logic [IDX_W-1:0] done_idx,
    output logic             pending
);

    generate
        if (DEPTH == (1 << IDX_W)) begin : g_pow2
            logic [IDX_W-1:0] gap;
            // natural wrap of the index width is the modulo
            assign gap     = prod_idx - done_idx;
            assign pending = (gap != '0);
        end else begin : g_mod
            logic [IDX_W:0] gap;
            // explicit wrap for a depth that is not a power of two
            always_comb begin
                if (prod_idx >= done_idx)
                    gap = {1'b0, prod_idx} - {1'b0, done_idx};
                else
                    gap = {1'b0, prod_idx} + (IDX_W+1)'(DEPTH) - {1'b0, done_idx};
            end
            assign pending = (gap != '0);
        end
    endgenerate

endmodule

// File: rtl/itm_token.sv
// Token keeper: holds the owner, the last-handled index and the
// interrupt pulse. Assumes hb_idx is below DEPTH.
module itm_token
    import itm_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pending,
    input  logic             hb_wr,
    input  logic [IDX_W-1:0] hb_idx,
    output owner_t           owner,
    output logic [IDX_W-1:0] done_idx,
    output logic             give_now,
    output logic             stray_now,
    output logic             irq_q
);

    owner_t           owner_q;
    logic [IDX_W-1:0] done_q;
    logic             take_now;

    // events decided from the current owner
    always_comb begin
        give_now  = (owner_q == OWNER_HW) && pending;
        take_now  = (owner_q == OWNER_DRV) && hb_wr;
        stray_now = (owner_q == OWNER_HW) && hb_wr;
    end

    // owner, last-handled index and interrupt pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWNER_HW;
            done_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= give_now;
            if (give_now)
                owner_q <= OWNER_DRV;
            else if (take_now) begin
                owner_q <= OWNER_HW;
                done_q  <= hb_idx;
            end
        end
    end

    assign owner    = owner_q;
    assign done_idx = done_q;

endmodule

// File: rtl/itm_status.sv
// Status word: cause flags with read-to-clear, owner mirror and the
// producer index captured at interrupt time. Set beats clear.
module itm_status
    import itm_pkg::*;
#(
    parameter int IDX_W = 4,
    localparam int STAT_W = IDX_W + ST_SNAP_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              give_now,
    input  logic              stray_now,
    input  logic              rd,
    input  logic [IDX_W-1:0]  snap_in,
    input  owner_t            owner,
    output logic [STAT_W-1:0] word
);

    logic             work_q;
    logic             err_q;
    logic [IDX_W-1:0] snap_q;

    // cause flags and snapshot register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= 1'b0;
            err_q  <= 1'b0;
            snap_q <= '0;
        end else begin
            if (give_now) begin
                work_q <= 1'b1;
                snap_q <= snap_in;
            end else if (rd)
                work_q <= 1'b0;
            if (stray_now)
                err_q <= 1'b1;
            else if (rd)
                err_q <= 1'b0;
        end
    end

    // pack the status word
    always_comb begin
        word                                  = '0;
        word[ST_WORK_BIT]                     = work_q;
        word[ST_ERR_BIT]                      = err_q;
        word[ST_OWN_BIT]                      = (owner == OWNER_DRV);
        word[ST_RSV_BIT]                      = 1'b0;
        word[ST_SNAP_LSB +: IDX_W]            = snap_q;
    end

endmodule

// File: rtl/irq_token_moderator.sv
// Top: registers the producer index, detects pending work, moves the
// single ownership token and reports status. Assumes indices < DEPTH.
module irq_token_moderator
    import itm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   prod_idx,
    input  logic               hb_wr,
    input  logic [IDX_W-1:0]   hb_idx,
    input  logic               stat_rd,
    output logic [IDX_W+3:0]   stat_data,
    output logic               drv_owns,
    output logic               irq_pulse
);

    logic [IDX_W-1:0] prod_q;
    logic [IDX_W-1:0] done_idx;
    logic             pending;
    logic             give_now;
    logic             stray_now;
    owner_t           owner;

    // register the producer index coming from the descriptor side
    always_ff @(posedge clk) begin
        if (!rst_n)
            prod_q <= '0;
        else
            prod_q <= prod_idx;
    end

    itm_gap #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_gap (
        .prod_idx (prod_q),
        .done_idx (done_idx),
        .pending  (pending)
    );

    itm_token #(.IDX_W(IDX_W)) u_token (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .hb_wr     (hb_wr),
        .hb_idx    (hb_idx),
        .owner     (owner),
        .done_idx  (done_idx),
        .give_now  (give_now),
        .stray_now (stray_now),
        .irq_q     (irq_pulse)
    );

    itm_status #(.IDX_W(IDX_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .give_now  (give_now),
        .stray_now (stray_now),
        .rd        (stat_rd),
        .snap_in   (prod_q),
        .owner     (owner),
        .word      (stat_data)
    );

    assign drv_owns = (owner == OWNER_DRV);

endmodule

// File: rtl/itm_checker.sv
// Protocol properties of the token moderator, bound to the top.
module itm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       hb_wr,
    input logic       stat_rd,
    input logic [1:0] cause,
    input logic       drv_owns,
    input logic       irq_pulse
);

    AST_IRQ_ON_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> (drv_owns && !$past(drv_owns)));                  // R7
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);                                      // R7
    AST_DRIVER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_owns && !hb_wr) |=> (drv_owns && !irq_pulse));             // R2
    AST_HANDBACK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_owns && hb_wr) |=> !drv_owns);                             // R4
    AST_STRAY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_owns && hb_wr) |=> cause[1]);                             // R6
    AST_CAUSE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> cause[0]);                                        // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && drv_owns) |=> !cause[0]);                           // R8

endmodule

bind irq_token_moderator itm_checker u_itm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .hb_wr     (hb_wr),
    .stat_rd   (stat_rd),
    .cause     (stat_data[1:0]),
    .drv_owns  (drv_owns),
    .irq_pulse (irq_pulse)
);

// File: tb/irq_token_moderator_bench.sv
module irq_token_moderator_bench;

    localparam int DEPTH = 16;
    localparam int IW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] prod_idx = '0;
    logic          hb_wr = 1'b0;
    logic [IW-1:0] hb_idx = '0;
    logic          stat_rd = 1'b0;
    logic [IW+3:0] stat_data;
    logic          drv_owns;
    logic          irq_pulse;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit model_on = 0;

    // reference model state
    int m_prodq, m_done, m_snap;
    bit m_hw, m_irq, m_work, m_err;

    irq_token_moderator #(.DEPTH(DEPTH)) u_irq_token_moderator (
        .clk(clk), .rst_n(rst_n), .prod_idx(prod_idx), .hb_wr(hb_wr),
        .hb_idx(hb_idx), .stat_rd(stat_rd), .stat_data(stat_data),
        .drv_owns(drv_owns), .irq_pulse(irq_pulse)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_prodq = 0; m_done = 0; m_snap = 0;
            m_hw = 1; m_irq = 0; m_work = 0; m_err = 0;
        end else begin
            bit fire, stray, take;
            fire  = m_hw && (((m_prodq - m_done + DEPTH) % DEPTH) != 0);
            stray = hb_wr && m_hw;
            take  = hb_wr && !m_hw;
            m_irq = fire;
            if (fire) begin m_hw = 0; m_work = 1; m_snap = m_prodq; end
            else if (stat_rd) m_work = 0;
            if (take) begin m_hw = 1; m_done = int'(hb_idx); end
            if (stray) m_err = 1;
            else if (stat_rd) m_err = 0;
            m_prodq = int'(prod_idx);
        end
    end

    // compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (model_on) begin
            logic [IW+3:0] exp;
            exp = {IW'(m_snap), 1'b0, !m_hw, m_err, m_work};
            check(irq_pulse == m_irq, "R2 R3 R5 R7 irq_pulse", irq_pulse, m_irq);
            check(drv_owns == !m_hw, "R4 R6 drv_owns", drv_owns, !m_hw);
            check(stat_data == exp, "R8 R9 stat_data", stat_data, exp);
        end
    end

    task automatic hand_back(input int idx);
        hb_idx = IW'(idx);
        hb_wr  = 1'b1;
        @(negedge clk);
        hb_wr  = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(irq_pulse == 1'b0, tag, irq_pulse, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1;
        // R1 reset state
        check(drv_owns == 0, "R1 owner", drv_owns, 0);
        check(irq_pulse == 0, "R1 irq", irq_pulse, 0);
        check(stat_data == 0, "R1 status", stat_data, 0);
        quiet(2, "R1 no irq with prod equal to zero");

        // R3 new work while hardware holds the token
        prod_idx = 4'd3;
        @(negedge clk); @(negedge clk);
        check(irq_pulse == 1, "R3 irq fires", irq_pulse, 1);
        check(drv_owns == 1, "R3 token to driver", drv_owns, 1);
        check(stat_data[IW+3:4] == 3, "R9 snapshot", stat_data[IW+3:4], 3);
        @(negedge clk);
        check(irq_pulse == 0, "R7 single cycle", irq_pulse, 0);

        // R2 driver holds the token: producer moves, no interrupt
        prod_idx = 4'd5;
        quiet(4, "R2 silent while driver owns");

        // R8 status read clears cause but keeps owner
        check(stat_data[0] == 1, "R8 cause before read", stat_data[0], 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check(stat_data[0] == 0, "R8 cause cleared", stat_data[0], 0);
        check(stat_data[2] == 1, "R8 R9 owner kept", stat_data[2], 1);

        // R4 hand-back with everything handled
        hand_back(5);
        check(drv_owns == 0, "R4 token returned", drv_owns, 0);
        quiet(3, "R4 no irq when caught up");

        // R6 stray hand-back is ignored and flagged
        hand_back(2);
        check(stat_data[1] == 1, "R6 error flag", stat_data[1], 1);
        quiet(3, "R6 stray index ignored");
        check(drv_owns == 0, "R6 owner unchanged", drv_owns, 0);

        // R5 hand-back with work already queued
        prod_idx = 4'd6;
        @(negedge clk); @(negedge clk);
        check(irq_pulse == 1, "R3 irq for index 6", irq_pulse, 1);
        prod_idx = 4'd7;
        hand_back(5);
        check(drv_owns == 0, "R5 token back", drv_owns, 0);
        @(negedge clk);
        check(irq_pulse == 1, "R5 immediate irq", irq_pulse, 1);
        check(stat_data[IW+3:4] == 7, "R5 R9 snapshot", stat_data[IW+3:4], 7);

        // R10 wrap-around of the index
        prod_idx = 4'd15;
        hand_back(15);
        quiet(3, "R10 no irq at last slot");
        prod_idx = 4'd0;
        @(negedge clk); @(negedge clk);
        check(irq_pulse == 1, "R10 wrapped index pending", irq_pulse, 1);
        hand_back(0);
        quiet(3, "R10 wrapped index handled");

        // random driver-like traffic checked against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            hb_wr   = 1'b0;
            stat_rd = 1'b0;
            if ($urandom_range(0, 3) == 0)
                prod_idx = IW'((int'(prod_idx) + $urandom_range(1, 3)) % DEPTH);
            if ($urandom_range(0, 5) == 0) begin
                hb_wr  = 1'b1;
                hb_idx = ($urandom_range(0, 2) == 0) ? IW'($urandom_range(0, DEPTH-1)) : prod_idx;
            end
            if ($urandom_range(0, 4) == 0)
                stat_rd = 1'b1;
        end
        @(negedge clk);
        hb_wr = 1'b0;
        stat_rd = 1'b0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // watchdog
    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule